// File: doc/BRIEF.md
# Keyboard Configuration Sequencer

After reset, this block puts an attached keyboard into a known state. It drives a fixed script of command bytes into a separate host-to-device byte transmitter. That transmitter is reached through a one-cycle load strobe and a data byte. The transmitter reports back on a busy line and an error line. The script has three parts:

- restore the keyboard defaults;
- select scan code set 2;
- switch on the Num Lock indicator.

The sequencer paces the script with a slow periodic frame tick (about 50 Hz). It never uses raw clock cycles for pacing. Each gap between bytes is a number of ticks. A longer settle gap follows the scan-set argument.

If the transmitter reports an error, the script restarts from its first byte. A limited number of attempts is allowed. Once the script ends, either in success or after the last failed attempt, a done flag rises and stays high until the next reset. A failure flag marks the unsuccessful case.

Top module: `kbd_init_seq`

## Requirements
- R1: The first byte loaded after reset, and after every restart, is 0xF6.
- R2: On a clean run exactly five bytes are loaded, in the order 0xF6, 0xF0, 0x02, 0xED, 0x02.
- R3: After a byte is accepted, the next load happens only after GAP_TICKS (default 2) frame ticks. This applies to every gap except the one after the third byte.
- R4: After the third byte (the scan-set argument 0x02) is accepted, SETTLE_TICKS (default 5) frame ticks pass before 0xED is loaded.
- R5: tx_load is a single-cycle pulse and is raised only in a cycle where tx_busy is low. tx_data holds the byte in that cycle. The transmitter raises tx_busy in the cycle after a load. A byte counts as accepted in the first later cycle where tx_busy is low and tx_error is low.
- R6: Gap waits count frame_tick pulses, not clock cycles. With no ticks, no further byte is loaded however long the wait.
- R7: A tx_error pulse seen while a byte is in flight causes an immediate restart from 0xF6, provided fewer than MAX_TRIES (default 3) attempts have been used.
- R8: An error on the final allowed attempt ends the run with done and failed both high. The failed flag is never high without done.
- R9: done rises after the final byte is accepted, or after R8 applies. It then stays high until reset, and no load happens while it is high.
- R10: In the first cycle after reset, done and failed are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_tick | input | 1 | One-cycle pulse that paces the waits |
| tx_busy | input | 1 | Transmitter is sending a byte |
| tx_error | input | 1 | Transmitter reports that the byte in flight failed |
| tx_data | output | 8 | Command byte offered to the transmitter |
| tx_load | output | 1 | One-cycle strobe that hands tx_data to the transmitter |
| done | output | 1 | Script finished; holds until reset |
| failed | output | 1 | Script gave up after the last allowed attempt |

## Verification
The bench builds the block with its default parameters: a two-tick gap, a five-tick settle and three attempts. It drives frame ticks every seven cycles, so a full script and a complete three-attempt failure both fit in a few hundred cycles. Three runs are made. One is clean and includes a long stretch with ticks held off. One has a single injected error on the third byte. One fails on every byte. Together these reach the restart path, the exhaustion path and the proof that waits ignore idle cycles.

// File: rtl/kbd_init_pkg.sv
// Package: types and the fixed command script shared by the sequencer.
// Assumes a script of five bytes; the gap after each byte is chosen in
// the script module from parameters.
package kbd_init_pkg;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2,
        ST_DONE = 2'd3
    } seq_state_t;

    localparam int SCRIPT_LEN  = 5;
    localparam int SETTLE_STEP = 2;   // the byte after which the long settle gap applies

    // Command byte at a given script position.
    function automatic logic [7:0] script_byte(input int idx);
        case (idx)
            0:       return 8'hF6;  // restore defaults
            1:       return 8'hF0;  // scan set select
            2:       return 8'h02;  // set 2
            3:       return 8'hED;  // indicator control
            default: return 8'h02;  // Num Lock lamp on
        endcase
    endfunction

endpackage

// File: rtl/kbd_init_script.sv
// Script lookup: gives the byte, the gap that follows it, and whether
// it is the final byte. Purely combinational; assumes step < SCRIPT_LEN.
module kbd_init_script
    import kbd_init_pkg::*;
#(
    parameter int GAP_TICKS    = 2,
    parameter int SETTLE_TICKS = 5,
    parameter int CNT_W        = 4,
    parameter int STEP_W       = 3
) (
    input  logic [STEP_W-1:0] step,
    output logic [7:0]        byte_o,
    output logic [CNT_W-1:0]  gap_o,
    output logic              last_o
);

    logic [7:0]       rom_byte [SCRIPT_LEN];
    logic [CNT_W-1:0] rom_gap  [SCRIPT_LEN];

    // Build the script table, one entry per step.
    for (genvar i = 0; i < SCRIPT_LEN; i++) begin : g_rom
        assign rom_byte[i] = script_byte(i);
        if (i == SETTLE_STEP) begin : g_settle
            assign rom_gap[i] = CNT_W'(SETTLE_TICKS);
        end else begin : g_plain
            assign rom_gap[i] = CNT_W'(GAP_TICKS);
        end
    end

    // Select the current entry; out-of-range steps read as the last one.
    always_comb begin
        if (int'(step) < SCRIPT_LEN) begin
            byte_o = rom_byte[step];
            gap_o  = rom_gap[step];
        end else begin
            byte_o = rom_byte[SCRIPT_LEN-1];
            gap_o  = rom_gap[SCRIPT_LEN-1];
        end
        last_o = (int'(step) >= SCRIPT_LEN - 1);
    end

endmodule

// File: rtl/kbd_tick_timer.sv
// Tick-counting wait timer. Loaded with a number of frame ticks; counts
// down only on ticks while running and flags the cycle of the final tick.
// Assumes load values of at least one.
module kbd_tick_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             frame_tick,
    output logic             expire
);

    logic [CNT_W-1:0] remain;

    // Last tick of the wait: the remaining count is one or less.
    assign expire = run && frame_tick && (remain <= CNT_W'(1));

    // Load, or count down one per tick while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (run && frame_tick && remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    // Without a tick or a load, the count does not move.
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !frame_tick) |=> $stable(remain));

endmodule

// File: rtl/kbd_retry_ctr.sv
// Attempt counter: counts failed attempts and flags the final allowed one.
// Cleared only by reset.
module kbd_retry_ctr #(
    parameter int MAX_TRIES = 3,
    parameter int TRY_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bump,
    output logic last_try
);

    logic [TRY_W-1:0] tries;

    assign last_try = (int'(tries) >= MAX_TRIES - 1);

    // Advance on every failed attempt that leads to a restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tries <= '0;
        end else if (bump && !last_try) begin
            tries <= tries + TRY_W'(1);
        end
    end

    p_tries_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tries) < MAX_TRIES);

endmodule

// File: rtl/kbd_init_seq.sv
// Keyboard configuration sequencer (top). Walks the command script, handing
// each byte to the transmitter when it is idle. It waits for each byte to be
// accepted, pauses a tick-counted gap, and restarts on transmitter errors.
// Assumes the transmitter raises tx_busy in the cycle after tx_load.
module kbd_init_seq
    import kbd_init_pkg::*;
#(
    parameter int GAP_TICKS    = 2,
    parameter int SETTLE_TICKS = 5,
    parameter int MAX_TRIES    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_tick,
    input  logic       tx_busy,
    input  logic       tx_error,
    output logic [7:0] tx_data,
    output logic       tx_load,
    output logic       done,
    output logic       failed
);

    localparam int MAX_GAP = (GAP_TICKS > SETTLE_TICKS) ? GAP_TICKS : SETTLE_TICKS;
    localparam int CNT_W   = $clog2(MAX_GAP + 1);
    localparam int STEP_W  = $clog2(SCRIPT_LEN);

    seq_state_t       state;
    logic [STEP_W-1:0] step;
    logic [CNT_W-1:0]  gap_len;
    logic              last_step;
    logic              gap_expire;
    logic              last_try;
    logic              accept;
    logic              err_seen;
    logic              fail_flag;

    kbd_init_script #(
        .GAP_TICKS   (GAP_TICKS),
        .SETTLE_TICKS(SETTLE_TICKS),
        .CNT_W       (CNT_W),
        .STEP_W      (STEP_W)
    ) u_script (
        .step  (step),
        .byte_o(tx_data),
        .gap_o (gap_len),
        .last_o(last_step)
    );

    kbd_tick_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_val  (gap_len),
        .run       (state == ST_GAP),
        .frame_tick(frame_tick),
        .expire    (gap_expire)
    );

    kbd_retry_ctr #(
        .MAX_TRIES(MAX_TRIES)
    ) u_retry (
        .clk     (clk),
        .rst_n   (rst_n),
        .bump    (err_seen),
        .last_try(last_try)
    );

    // Transfer outcome decode and load strobe.
    always_comb begin
        err_seen = (state == ST_XFER) && tx_error;
        accept   = (state == ST_XFER) && !tx_error && !tx_busy;
        tx_load  = (state == ST_LOAD) && !tx_busy;
    end

    assign done   = (state == ST_DONE);
    assign failed = fail_flag;

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_LOAD;
            step      <= '0;
            fail_flag <= 1'b0;
        end else begin
            case (state)
                ST_LOAD: if (tx_load) state <= ST_XFER;
                ST_XFER: begin
                    if (err_seen) begin
                        step <= '0;
                        if (last_try) begin
                            state     <= ST_DONE;
                            fail_flag <= 1'b1;
                        end else begin
                            state <= ST_LOAD;
                        end
                    end else if (accept) begin
                        if (last_step) begin
                            state <= ST_DONE;
                        end else begin
                            step  <= step + STEP_W'(1);
                            state <= ST_GAP;
                        end
                    end
                end
                ST_GAP:  if (gap_expire) state <= ST_LOAD;
                default: state <= ST_DONE;
            endcase
        end
    end

    p_load_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> !tx_busy);
    p_load_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load);
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    p_quiet_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !tx_load);
    p_fail_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        failed |-> done);
    p_restart_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && tx_error && !last_try) |=> (tx_data == 8'hF6));

endmodule

// File: tb/kbd_init_seq_test.sv
module kbd_init_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 1'b0;
    logic       tx_busy = 1'b1;
    logic       tx_error = 1'b0;
    logic [7:0] tx_data;
    logic       tx_load;
    logic       done;
    logic       failed;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    kbd_init_seq uut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .tx_busy(tx_busy), .tx_error(tx_error),
        .tx_data(tx_data), .tx_load(tx_load),
        .done(done), .failed(failed)
    );

    // Bench-side configuration
    int  err_mode = 0;     // 0 none, 1 error on third load, 2 error on every load
    bit  tick_en  = 1'b1;
    bit  load_seen = 1'b0;
    int  loads_n = 0;
    int  busy_left = 0;
    bit  inj = 1'b0;
    int  tick_ctr = 0;

    function automatic logic [7:0] exp_byte(input int i);
        logic [7:0] s [5] = '{8'hF6, 8'hF0, 8'h02, 8'hED, 8'h02};
        return s[i];
    endfunction
    function automatic int exp_gap(input int i);
        return (i == 2) ? 5 : 2;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Transmitter and tick emulation, driven just after the rising edge.
    always @(posedge clk) begin
        #1;
        tx_error <= 1'b0;
        tick_ctr++;
        frame_tick <= tick_en && (tick_ctr % 7 == 0);
        if (!rst_n) begin
            tx_busy <= 1'b1; busy_left = 4; inj = 1'b0; loads_n = 0;
        end else if (load_seen) begin
            loads_n++;
            tx_busy <= 1'b1; busy_left = 3;
            inj = (err_mode == 2) || (err_mode == 1 && loads_n == 3);
        end else if (busy_left > 0) begin
            busy_left--;
            if (busy_left == 0) begin
                tx_busy <= 1'b0;
                if (inj) tx_error <= 1'b1;
                inj = 1'b0;
            end
        end
    end

    // Reference model, compared on every falling edge.
    int m_phase = 0, m_idx = 0, m_cnt = 0, m_gap = 0, m_tries = 0;
    bit m_failed = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_idx = 0; m_cnt = 0; m_tries = 0; m_failed = 0;
            load_seen = 1'b0;
        end else begin
            bit exp_load;
            exp_load = (m_phase == 0) && !tx_busy;
            // R5 single-cycle load only when idle; timing also covers R3 R4 R6 gaps
            check(tx_load == exp_load, "R5 tx_load timing", tx_load, exp_load);
            if (exp_load && tx_load) begin
                if (m_idx == 0) check(tx_data == 8'hF6, "R1 first byte", tx_data, 8'hF6);
                else check(tx_data == exp_byte(m_idx), "R2 byte order", tx_data, exp_byte(m_idx));
            end
            check(done == (m_phase == 3), "R9 done", done, m_phase == 3);
            check(failed == m_failed, "R8 failed", failed, m_failed);
            load_seen = tx_load;
            case (m_phase)
                0: if (!tx_busy) m_phase = 1;
                1: if (tx_error) begin
                        m_idx = 0;
                        if (m_tries == 2) begin m_phase = 3; m_failed = 1; end
                        else begin m_tries++; m_phase = 0; end
                   end else if (!tx_busy) begin
                        if (m_idx == 4) m_phase = 3;
                        else begin m_gap = exp_gap(m_idx); m_idx++; m_cnt = 0; m_phase = 2; end
                   end
                2: if (frame_tick) begin m_cnt++; if (m_cnt == m_gap) m_phase = 0; end
                default: ;
            endcase
        end
    end

    task automatic do_reset(input int mode, input bit ticks);
        @(posedge clk); #1;
        rst_n = 1'b0; err_mode = mode; tick_en = ticks;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && failed == 1'b0, "R10 reset state", {done, failed}, 0);
    endtask

    task automatic wait_done;
        for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
    endtask

    initial begin
        // Clean run, with ticks held off after the first byte (R6)
        do_reset(0, 1'b0);
        for (int i = 0; i < 200 && loads_n < 1; i++) @(negedge clk);
        repeat (100) @(negedge clk);
        check(loads_n == 1, "R6 no load without ticks", loads_n, 1);
        tick_en = 1'b1;
        wait_done();
        check(done && !failed, "R9 clean done", {done, failed}, 2);
        check(loads_n == 5, "R2 clean byte count", loads_n, 5);
        repeat (60) @(negedge clk);
        check(loads_n == 5 && done, "R9 quiet after done", loads_n, 5);

        // One error on the third byte: restart from 0xF6 (R7)
        do_reset(1, 1'b1);
        wait_done();
        check(done && !failed, "R7 recovered run", {done, failed}, 2);
        check(loads_n == 8, "R7 restart byte count", loads_n, 8);

        // Error on every byte: three attempts, then failure (R8)
        do_reset(2, 1'b1);
        wait_done();
        check(done && failed, "R8 exhausted", {done, failed}, 3);
        check(loads_n == 3, "R8 attempt count", loads_n, 3);
        repeat (40) @(negedge clk);
        check(done && failed && loads_n == 3, "R9 hold after fail", loads_n, 3);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule